// File: doc/BRIEF.md
# Scaled Radix-2 Decimation-in-Time Butterfly

This block computes one complex radix-2 decimation-in-time butterfly per clock cycle in signed 16-bit fixed point. Each accepted input carries two complex operands, A and B, and a complex twiddle factor W. The block produces A' = A/2 + W·B/2 and B' = A/2 − W·B/2. All data and twiddle values use the signed Q1.15 format, and the value +1 is written as 0x7FFF.

Both operands are halved before they are combined, so an FFT stage built from this block keeps a constant word width. The block forms four real partial products of W·B. It rounds each product back to 16 bits as soon as it is formed, and only then sums the products into the real and imaginary parts of the complex product.

The datapath is a three-register pipeline with no back-pressure. A sequencer places one butterfly on the input each cycle with the valid bit set, and reads the two results when the output valid bit is high. Twiddle generation and address sequencing belong to the surrounding FFT engine.

Top module: `bfly_r2_dit`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and all four result outputs are 0.
- R2: A butterfly captured at clock edge k appears on the outputs after edge k+2, with `out_valid` high for exactly that cycle. Back-to-back inputs produce back-to-back outputs in the same order.
- R3: A/2 is an arithmetic right shift of each component of A by one bit, which discards the LSB. For example, −1 halves to −1, and with B = 0 both results equal A/2.
- R4: Each of the four products Wre·Bre, Wim·Bim, Wre·Bim and Wim·Br is a 32-bit signed product rounded half-up to 16 bits: 2^14 is added and bits [30:15] are kept.
- R5: The single product that cannot be represented, (−32768)·(−32768), rounds to +32767 instead of wrapping.
- R6: T_re = r(Wre·Bre) − r(Wim·Bim) and T_im = r(Wre·Bim) + r(Wim·Bre) are formed in 17 bits. T is halved by an arithmetic shift of one bit. Then A' = A/2 + T/2 and B' = A/2 − T/2 for each component.
- R7: Every final sum or difference outside [−32768, 32767] is clamped to the nearest limit.
- R8: While `out_valid` is low, the four result outputs keep the values of the most recent valid result, or 0 after reset.
- R9: The operand and twiddle inputs have no effect while `in_valid` is low. The outputs do not change, and later results are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and twiddle are valid this cycle |
| in_a_re | input | 16 | Operand A, real part (Q1.15) |
| in_a_im | input | 16 | Operand A, imaginary part |
| in_b_re | input | 16 | Operand B, real part |
| in_b_im | input | 16 | Operand B, imaginary part |
| in_w_re | input | 16 | Twiddle, real part |
| in_w_im | input | 16 | Twiddle, imaginary part |
| out_valid | output | 1 | Results are valid this cycle |
| out_a_re | output | 16 | A', real part |
| out_a_im | output | 16 | A', imaginary part |
| out_b_re | output | 16 | B', real part |
| out_b_im | output | 16 | B', imaginary part |

## Verification
Random operands almost never reach the two rarest paths. One is the product whose operands are both −32768, which must saturate. The other is a final sum that leaves the 16-bit range, which needs near-full-scale A together with a twiddle and B aligned so that both partial products push the same way.

Directed tasks build these cases on purpose. Full-scale operands with opposing signs in the imaginary parts drive T/2 to about 32766, and the clamp is checked in both directions. Half-valued twiddles with odd operands land exactly on rounding ties.

Every result is compared bit for bit against an integer model kept in the bench. The same stream interleaves idle cycles that carry junk operands, which shows that the outputs hold and that later results are unaffected.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

    localparam int BFLY_DW_DEF  = 16;
    localparam int BFLY_LATENCY = 3;

    // Index of each real partial product of W*B
    typedef enum logic [1:0] {
        PROD_RR = 2'd0,   // Wre * Bre
        PROD_II = 2'd1,   // Wim * Bim
        PROD_RI = 2'd2,   // Wre * Bim
        PROD_IR = 2'd3    // Wim * Bre
    } prod_sel_e;

    localparam int PROD_COUNT = 4;

endpackage

// File: rtl/bfly_round.sv
// Rounds one 2*DW-bit signed product back to DW bits, half-up, with the
// single unrepresentable product (-1 * -1) clamped to the positive limit.
module bfly_round #(
    parameter int DW = 16
) (
    input  logic signed [2*DW-1:0] prod_i,
    output logic signed [DW-1:0]   rnd_o
);
    localparam int PW = 2 * DW;
    localparam logic signed [PW-1:0] HALF_LSB =
        {{(DW + 1){1'b0}}, 1'b1, {(DW - 2){1'b0}}};
    localparam logic signed [PW-1:0] PROD_MAX = {2'b01, {(PW - 2){1'b0}}};
    localparam logic signed [DW-1:0] OUT_MAX  = {1'b0, {(DW - 1){1'b1}}};

    logic signed [PW-1:0] biased;

    always_comb begin
        biased = prod_i + HALF_LSB;
        if (prod_i == PROD_MAX) begin
            rnd_o = OUT_MAX;
        end else begin
            rnd_o = DW'(biased >>> (DW - 1));
        end
    end
endmodule

// File: rtl/bfly_cmul.sv
// Two pipeline stages: partial products, then rounding and combination.
module bfly_cmul
    import bfly_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 v_i,
    input  logic signed [DW-1:0] b_re_i,
    input  logic signed [DW-1:0] b_im_i,
    input  logic signed [DW-1:0] w_re_i,
    input  logic signed [DW-1:0] w_im_i,
    output logic                 v1_o,
    output logic                 v2_o,
    output logic signed [DW:0]   t_re_o,
    output logic signed [DW:0]   t_im_o
);
    localparam int PW   = 2 * DW;
    localparam int XW   = DW + 1;
    localparam int I_RR = int'(PROD_RR);
    localparam int I_II = int'(PROD_II);
    localparam int I_RI = int'(PROD_RI);
    localparam int I_IR = int'(PROD_IR);

    logic signed [PW-1:0] prod_q [PROD_COUNT];
    logic signed [DW-1:0] rnd_w  [PROD_COUNT];
    logic                 v1_q;
    logic                 v2_q;
    logic signed [XW-1:0] t_re_q;
    logic signed [XW-1:0] t_im_q;
    logic signed [XW-1:0] t_re_d;
    logic signed [XW-1:0] t_im_d;

    // Stage 1: full-precision partial products
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q <= 1'b0;
            for (int k = 0; k < PROD_COUNT; k++) begin
                prod_q[k] <= '0;
            end
        end else begin
            v1_q <= v_i;
            if (v_i) begin
                prod_q[I_RR] <= w_re_i * b_re_i;
                prod_q[I_II] <= w_im_i * b_im_i;
                prod_q[I_RI] <= w_re_i * b_im_i;
                prod_q[I_IR] <= w_im_i * b_re_i;
            end
        end
    end

    // Each product is rounded to DW bits before it is combined
    for (genvar gi = 0; gi < PROD_COUNT; gi++) begin : g_round
        bfly_round #(.DW(DW)) u_round (
            .prod_i (prod_q[gi]),
            .rnd_o  (rnd_w[gi])
        );
    end

    always_comb begin
        t_re_d = XW'(rnd_w[I_RR]) - XW'(rnd_w[I_II]);
        t_im_d = XW'(rnd_w[I_RI]) + XW'(rnd_w[I_IR]);
    end

    // Stage 2: complex product held at DW+1 bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v2_q   <= 1'b0;
            t_re_q <= '0;
            t_im_q <= '0;
        end else begin
            v2_q <= v1_q;
            if (v1_q) begin
                t_re_q <= t_re_d;
                t_im_q <= t_im_d;
            end
        end
    end

    assign v1_o   = v1_q;
    assign v2_o   = v2_q;
    assign t_re_o = t_re_q;
    assign t_im_o = t_im_q;
endmodule

// File: rtl/bfly_addsub.sv
// Stage 3: halve T, form sum and difference with A/2, clamp to DW bits.
module bfly_addsub #(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 v_i,
    input  logic signed [DW-1:0] ah_re_i,
    input  logic signed [DW-1:0] ah_im_i,
    input  logic signed [DW:0]   t_re_i,
    input  logic signed [DW:0]   t_im_i,
    output logic                 v_o,
    output logic signed [DW-1:0] a_re_o,
    output logic signed [DW-1:0] a_im_o,
    output logic signed [DW-1:0] b_re_o,
    output logic signed [DW-1:0] b_im_o
);
    localparam int XW    = DW + 1;
    localparam int NCOMP = 2;   // real, imaginary
    localparam logic signed [XW-1:0] LIM_HI = {2'b00, {(DW - 1){1'b1}}};
    localparam logic signed [XW-1:0] LIM_LO = {2'b11, {(DW - 1){1'b0}}};

    function automatic logic signed [DW-1:0] clamp(input logic signed [XW-1:0] x);
        if (x > LIM_HI) begin
            return LIM_HI[DW-1:0];
        end else if (x < LIM_LO) begin
            return LIM_LO[DW-1:0];
        end
        return x[DW-1:0];
    endfunction

    logic signed [DW-1:0] ah   [NCOMP];
    logic signed [XW-1:0] tt   [NCOMP];
    logic signed [DW-1:0] sum_d[NCOMP];
    logic signed [DW-1:0] dif_d[NCOMP];
    logic signed [DW-1:0] sum_q[NCOMP];
    logic signed [DW-1:0] dif_q[NCOMP];
    logic                 v_q;

    assign ah[0] = ah_re_i;
    assign ah[1] = ah_im_i;
    assign tt[0] = t_re_i;
    assign tt[1] = t_im_i;

    for (genvar gc = 0; gc < NCOMP; gc++) begin : g_comp
        logic signed [XW-1:0] th;
        logic signed [XW-1:0] s_wide;
        logic signed [XW-1:0] d_wide;
        always_comb begin
            th     = tt[gc] >>> 1;
            s_wide = XW'(ah[gc]) + th;
            d_wide = XW'(ah[gc]) - th;
            sum_d[gc] = clamp(s_wide);
            dif_d[gc] = clamp(d_wide);
        end
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sum_q[gc] <= '0;
                dif_q[gc] <= '0;
            end else if (v_i) begin
                sum_q[gc] <= sum_d[gc];
                dif_q[gc] <= dif_d[gc];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= 1'b0;
        end else begin
            v_q <= v_i;
        end
    end

    assign v_o    = v_q;
    assign a_re_o = sum_q[0];
    assign a_im_o = sum_q[1];
    assign b_re_o = dif_q[0];
    assign b_im_o = dif_q[1];
endmodule

// File: rtl/bfly_r2_dit.sv
module bfly_r2_dit
    import bfly_pkg::*;
#(
    parameter int DW = BFLY_DW_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_a_re,
    input  logic signed [DW-1:0] in_a_im,
    input  logic signed [DW-1:0] in_b_re,
    input  logic signed [DW-1:0] in_b_im,
    input  logic signed [DW-1:0] in_w_re,
    input  logic signed [DW-1:0] in_w_im,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_a_re,
    output logic signed [DW-1:0] out_a_im,
    output logic signed [DW-1:0] out_b_re,
    output logic signed [DW-1:0] out_b_im
);
    logic                 v1;
    logic                 v2;
    logic signed [DW:0]   t_re;
    logic signed [DW:0]   t_im;
    logic signed [DW-1:0] ah1_re_q;
    logic signed [DW-1:0] ah1_im_q;
    logic signed [DW-1:0] ah2_re_q;
    logic signed [DW-1:0] ah2_im_q;

    bfly_cmul #(.DW(DW)) u_cmul (
        .clk    (clk),
        .rst_n  (rst_n),
        .v_i    (in_valid),
        .b_re_i (in_b_re),
        .b_im_i (in_b_im),
        .w_re_i (in_w_re),
        .w_im_i (in_w_im),
        .v1_o   (v1),
        .v2_o   (v2),
        .t_re_o (t_re),
        .t_im_o (t_im)
    );

    // A is halved on entry and travels beside the product stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ah1_re_q <= '0;
            ah1_im_q <= '0;
            ah2_re_q <= '0;
            ah2_im_q <= '0;
        end else begin
            if (in_valid) begin
                ah1_re_q <= in_a_re >>> 1;
                ah1_im_q <= in_a_im >>> 1;
            end
            if (v1) begin
                ah2_re_q <= ah1_re_q;
                ah2_im_q <= ah1_im_q;
            end
        end
    end

    bfly_addsub #(.DW(DW)) u_addsub (
        .clk     (clk),
        .rst_n   (rst_n),
        .v_i     (v2),
        .ah_re_i (ah2_re_q),
        .ah_im_i (ah2_im_q),
        .t_re_i  (t_re),
        .t_im_i  (t_im),
        .v_o     (out_valid),
        .a_re_o  (out_a_re),
        .a_im_o  (out_a_im),
        .b_re_o  (out_b_re),
        .b_im_o  (out_b_im)
    );
endmodule

// File: rtl/bfly_r2_dit_chk.sv
module bfly_r2_dit_chk #(
    parameter int DW = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic signed [DW-1:0] in_b_re,
    input logic signed [DW-1:0] in_b_im,
    input logic signed [DW-1:0] in_w_re,
    input logic signed [DW-1:0] in_w_im,
    input logic                 out_valid,
    input logic signed [DW-1:0] out_a_re,
    input logic signed [DW-1:0] out_a_im,
    input logic signed [DW-1:0] out_b_re,
    input logic signed [DW-1:0] out_b_im
);
    // Clock edges since reset release, saturating at the pipeline depth
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_a_re == '0 && out_a_im == '0
                    && out_b_re == '0 && out_b_im == '0));

    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && !out_valid) |->
            ($stable(out_a_re) && $stable(out_a_im)
             && $stable(out_b_re) && $stable(out_b_im)));

    a_r3_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && out_valid
         && $past(in_b_re, 3) == '0 && $past(in_b_im, 3) == '0) |->
            (out_a_re == out_b_re && out_a_im == out_b_im));

    a_r6_zero_w: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && out_valid
         && $past(in_w_re, 3) == '0 && $past(in_w_im, 3) == '0) |->
            (out_a_re == out_b_re && out_a_im == out_b_im));
endmodule

bind bfly_r2_dit bfly_r2_dit_chk #(.DW(DW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_b_re   (in_b_re),
    .in_b_im   (in_b_im),
    .in_w_re   (in_w_re),
    .in_w_im   (in_w_im),
    .out_valid (out_valid),
    .out_a_re  (out_a_re),
    .out_a_im  (out_a_im),
    .out_b_re  (out_b_re),
    .out_b_im  (out_b_im)
);

// File: tb/bfly_r2_dit_tb_top.sv
`timescale 1ns/1ps
module bfly_r2_dit_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [15:0] in_a_re = '0, in_a_im = '0, in_b_re = '0, in_b_im = '0;
    logic signed [15:0] in_w_re = '0, in_w_im = '0;
    logic out_valid;
    logic signed [15:0] out_a_re, out_a_im, out_b_re, out_b_im;

    int checks = 0;
    int errors = 0;

    // Expected-result delay line, index 2 is due at the current sample point
    int    e_v [3];
    int    e_ar[3], e_ai[3], e_br[3], e_bi[3];
    string e_tag[3];
    int    h_ar = 0, h_ai = 0, h_br = 0, h_bi = 0;

    always #10 clk = ~clk;   // 50 MHz

    bfly_r2_dit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_a_re(in_a_re), .in_a_im(in_a_im), .in_b_re(in_b_re), .in_b_im(in_b_im),
        .in_w_re(in_w_re), .in_w_im(in_w_im), .out_valid(out_valid),
        .out_a_re(out_a_re), .out_a_im(out_a_im), .out_b_re(out_b_re), .out_b_im(out_b_im)
    );

    function automatic int rnd(int x, int y);
        longint p = longint'(x) * longint'(y);
        if (p == 64'sd1073741824) return 32767;
        return int'((p + 64'sd16384) >>> 15);
    endfunction

    function automatic int clip(int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic check_out();
        int gv = int'(out_valid);
        int xa = h_ar, xb = h_ai, xc = h_br, xd = h_bi;
        if (e_v[2] != 0) begin
            xa = e_ar[2]; xb = e_ai[2]; xc = e_br[2]; xd = e_bi[2];
            h_ar = xa; h_ai = xb; h_br = xc; h_bi = xd;
        end
        checks++;
        if (gv != e_v[2] || int'(out_a_re) != xa || int'(out_a_im) != xb
            || int'(out_b_re) != xc || int'(out_b_im) != xd) begin
            errors++;
            $display("FAIL %s: got v=%0d A'=(%0d,%0d) B'=(%0d,%0d) expected v=%0d A'=(%0d,%0d) B'=(%0d,%0d)",
                     e_tag[2], gv, out_a_re, out_a_im, out_b_re, out_b_im,
                     e_v[2], xa, xb, xc, xd);
        end
    endtask

    task automatic step(input int v, input int ar, input int ai, input int br, input int bi,
                        input int wr, input int wi, input string tag);
        int trr, tim;
        @(negedge clk);
        check_out();
        for (int k = 2; k > 0; k--) begin
            e_v[k] = e_v[k-1]; e_ar[k] = e_ar[k-1]; e_ai[k] = e_ai[k-1];
            e_br[k] = e_br[k-1]; e_bi[k] = e_bi[k-1]; e_tag[k] = e_tag[k-1];
        end
        trr = rnd(wr, br) - rnd(wi, bi);
        tim = rnd(wr, bi) + rnd(wi, br);
        e_v[0]  = v;
        e_ar[0] = clip((ar >>> 1) + (trr >>> 1));
        e_ai[0] = clip((ai >>> 1) + (tim >>> 1));
        e_br[0] = clip((ar >>> 1) - (trr >>> 1));
        e_bi[0] = clip((ai >>> 1) - (tim >>> 1));
        e_tag[0] = (v != 0) ? tag : ((tag == "R9") ? "R9" : "R8");
        in_valid = (v != 0);
        in_a_re = ar[15:0]; in_a_im = ai[15:0];
        in_b_re = br[15:0]; in_b_im = bi[15:0];
        in_w_re = wr[15:0]; in_w_im = wi[15:0];
    endtask

    task automatic flush();
        for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0, 0, 0, "R8");
    endtask

    task automatic t_reset();
        for (int k = 0; k < 3; k++) begin
            e_v[k] = 0; e_ar[k] = 0; e_ai[k] = 0; e_br[k] = 0; e_bi[k] = 0; e_tag[k] = "R1";
        end
        rst_n = 1'b0;
        in_valid = 1'b1;   // must be ignored while in reset
        in_a_re = 16'sd1000; in_b_re = 16'sd2000; in_w_re = 16'sh7FFF;
        repeat (4) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_a_re != 0 || out_a_im != 0 || out_b_re != 0 || out_b_im != 0) begin
            errors++;
            $display("FAIL R1: got v=%0d A'=(%0d,%0d) B'=(%0d,%0d) expected all 0",
                     out_valid, out_a_re, out_a_im, out_b_re, out_b_im);
        end
        in_valid = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_halving();
        step(1, -1, 1, 0, 0, 32767, 0, "R3");
        step(1, -32768, 32767, 0, 0, 12345, -777, "R3");
        step(1, -3, 5, 0, 0, 0, 32767, "R3");
        step(1, 7, -7, 0, 0, -32768, -32768, "R3");
        flush();
    endtask

    task automatic t_round();
        step(1, 0, 0, 1, -1, 16384, 0, "R4");
        step(1, 0, 0, 3, -3, 16384, 0, "R4");
        step(1, 2, 2, 5, -5, 0, 16384, "R4");
        step(1, 0, 0, 32767, -32767, 1, 1, "R4");
        step(1, 0, 0, -1, 1, 16384, 16384, "R4");
        flush();
    endtask

    task automatic t_psat();
        step(1, 0, 0, -32768, 0, -32768, 0, "R5");
        step(1, 0, 0, 0, -32768, 0, -32768, "R5");
        step(1, 100, -100, -32768, -32768, -32768, -32768, "R5");
        flush();
    endtask

    task automatic t_combine();
        step(1, 1000, -2000, 3000, 4000, 23170, -23170, "R6");
        step(1, -12000, 9000, -7000, 15000, 30273, 12539, "R6");
        step(1, 32767, 32767, 32767, 32767, 32767, 0, "R6");
        step(1, -5, 4, 9999, -8888, -12539, 30273, "R6");
        flush();
    endtask

    task automatic t_osat();
        step(1, 32767, 32767, 32767, -32768, 32767, 32767, "R7");
        step(1, -32768, -32768, 32767, -32768, 32767, 32767, "R7");
        step(1, -32768, 32767, -32768, -32768, 32767, -32768, "R7");
        flush();
    endtask

    task automatic t_stream();
        for (int k = 0; k < 6; k++)
            step(1, 1000 * k - 2500, 300 - 111 * k, 4000 - 900 * k, 700 * k,
                 23170 - 5000 * k, 3000 * k - 9000, "R2");
        step(0, 31000, -31000, 29000, -29000, 32767, 32767, "R9");
        step(1, 500, -600, 700, -800, 16384, -16384, "R2");
        step(0, -12345, 2222, -3333, 4444, -32768, 5555, "R9");
        step(0, 9, 9, 9, 9, 9, 9, "R9");
        step(1, -500, 600, -700, 800, -16384, 16384, "R2");
        flush();
        flush();
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_halving();
                t_round();
                t_psat();
                t_combine();
                t_osat();
                t_stream();
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule